// File: doc/BRIEF.md
# Modem Line Status Change Detector

This block holds the modem status byte of a 16550-style serial port. Four modem input lines come in asynchronously: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line passes through a synchroniser. Its settled level is shown in the upper nibble of the status byte. A sticky change flag for each line is shown in the lower nibble.

A host reads the byte combinationally at any time. It pulses `rd_stb` for one clock to mark a read, and that clock edge clears the change flags. A change arriving on that same edge is kept, so no event is lost. An interrupt request is raised while any flag is set and the enable input is high.

A two-state machine guards the flags after reset. In `ST_FILL` the synchroniser and edge registers fill with real line values, and change detection is masked. The transition `FILL_DONE` moves to `ST_ARMED` after `SYNC_STAGES+1` clocks. `ST_ARMED` is held until the next reset, through the transition `STAY_ARMED`.

Top module: `mdm_stat_track`

## Requirements
- R1: While `rst_n` is low, `stat_q` is 8'h00 and `irq` is 0.
- R2: A level change on `line_in[i]` (0 = CTS, 1 = DSR, 2 = RI, 3 = DCD) appears on `stat_q[4+i]` after the second rising clock edge, and not after the first.
- R3: For CTS, DSR and DCD, either a rising or a falling level sets the change flag at `stat_q[0]`, `stat_q[1]` and `stat_q[3]` respectively. The flag appears one edge after the new level appears.
- R4: `stat_q[2]` sets only when RI goes from 1 to 0. A rise of RI leaves it unchanged.
- R5: A set flag stays set without a read, through any number of further changes on its line.
- R6: A clock edge with `rd_stb` high clears all flags that have no new event on that edge. During the strobe cycle, `stat_q` still shows the value from before the clear.
- R7: An event that is detected on the same edge as a read leaves its flag set after the read.
- R8: `irq` equals `irq_en` AND the OR of `stat_q[3:0]`. With `irq_en` low, flags are still recorded.
- R9: For the first `SYNC_STAGES+1` clocks after reset, no flag is set. Lines that are already high at reset therefore produce no flag.
- R10: A change on one line sets only that line's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 4 | Raw modem lines, 1 = asserted: [0] CTS, [1] DSR, [2] RI, [3] DCD |
| rd_stb | input | 1 | One-cycle host read strobe; clears flags at its clock edge |
| irq_en | input | 1 | Modem-status interrupt enable |
| stat_q | output | 8 | Status byte: [7:4] levels DCD,RI,DSR,CTS; [3:0] flags DCD,RI-trailing,DSR,CTS |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach is a read strobe that lands exactly on the edge where a new change is first detected. The bench gets there by counting edges from the input change. It drives DCD on a falling edge, lets two rising edges pass so the new level has just settled, and then raises `rd_stb` across the third edge. After that edge the DCD flag must still be set. The post-reset masking is reached by holding every line high through reset. The bench then confirms that no flag appears once the machine is armed.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int LINE_CNT = 4;
    localparam int IDX_CTS  = 0;
    localparam int IDX_DSR  = 1;
    localparam int IDX_RI   = 2;
    localparam int IDX_DCD  = 3;

    typedef enum logic [0:0] {
        ST_FILL  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_e;

    typedef enum logic [0:0] {
        DET_ANY  = 1'b0,
        DET_FALL = 1'b1
    } det_mode_e;

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg[0] <= '0;
        end else begin
            stg[0] <= d;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg[s] <= '0;
                end else begin
                    stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/mdm_delta_cell.sv
module mdm_delta_cell
    import mdm_pkg::*;
#(
    parameter det_mode_e MODE = DET_ANY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic arm,
    input  logic clr,
    output logic flag
);

    logic prev_lvl;
    logic hit;

    generate
        if (MODE == DET_FALL) begin : g_fall
            assign hit = prev_lvl & ~level;
        end else begin : g_any
            assign hit = prev_lvl ^ level;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_lvl <= 1'b0;
            flag     <= 1'b0;
        end else begin
            prev_lvl <= level;
            flag     <= (flag & ~clr) | (hit & arm);
        end
    end

endmodule

// File: rtl/mdm_stat_track.sv
module mdm_stat_track
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] line_in,
    input  logic       rd_stb,
    input  logic       irq_en,
    output logic [7:0] stat_q,
    output logic       irq
);

    localparam int SETTLE = SYNC_STAGES + 1;
    localparam int CW     = $clog2(SETTLE + 1);

    arm_state_e          state_q, state_d;
    logic [CW-1:0]       fill_cnt;
    logic                armed;
    logic [LINE_CNT-1:0] lvl;
    logic [LINE_CNT-1:0] delta;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Fill counter, only running in ST_FILL
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_cnt <= '0;
        end else if (state_q == ST_FILL) begin
            fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // Next state: FILL_DONE and STAY_ARMED
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (fill_cnt == CW'(SETTLE - 1)) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                state_d = ST_ARMED;
            end
        endcase
    end

    // State outputs
    always_comb begin
        armed = 1'b0;
        unique case (state_q)
            ST_FILL:  armed = 1'b0;
            ST_ARMED: armed = 1'b1;
        endcase
    end

    mdm_sync #(
        .W      (LINE_CNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (lvl)
    );

    generate
        for (genvar i = 0; i < LINE_CNT; i++) begin : g_line
            if (i == IDX_RI) begin : g_trail
                mdm_delta_cell #(.MODE(DET_FALL)) u_cell (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .level (lvl[i]),
                    .arm   (armed),
                    .clr   (rd_stb),
                    .flag  (delta[i])
                );
            end else begin : g_both
                mdm_delta_cell #(.MODE(DET_ANY)) u_cell (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .level (lvl[i]),
                    .arm   (armed),
                    .clr   (rd_stb),
                    .flag  (delta[i])
                );
            end
        end
    endgenerate

    assign stat_q = {lvl, delta};
    assign irq    = irq_en & (|delta);

endmodule

// File: rtl/mdm_stat_track_chk.sv
module mdm_stat_track_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       irq_en,
    input logic       irq,
    input logic [7:0] stat_q,
    input logic       armed
);

    // R8: enable low masks the request
    p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R8: any flag with enable raises the request
    p_irq_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && (stat_q[3:0] != 4'h0)) |-> irq);

    // R5: without a read no flag drops
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0])));

    // R3: a CTS level change sets its flag one edge later
    p_cts_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $changed(stat_q[4])) |=> stat_q[0]);

    // R4: RI falling sets the trailing-edge flag
    p_ri_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(stat_q[6])) |=> stat_q[2]);

    // R4: RI rising leaves a clear trailing-edge flag clear
    p_ri_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(stat_q[6]) && !stat_q[2]) |=> !stat_q[2]);

    // R9: nothing is recorded while filling
    p_fill_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (stat_q[3:0] == 4'h0));

endmodule

bind mdm_stat_track mdm_stat_track_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_stb (rd_stb),
    .irq_en (irq_en),
    .irq    (irq),
    .stat_q (stat_q),
    .armed  (armed)
);

// File: tb/mdm_stat_track_test.sv
module mdm_stat_track_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] line_in = 4'hF;
    logic       rd_stb = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] stat_q;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mdm_stat_track uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .rd_stb  (rd_stb),
        .irq_en  (irq_en),
        .stat_q  (stat_q),
        .irq     (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle read; returns value seen during the strobe
    task automatic host_read(output logic [7:0] v);
        rd_stb = 1'b1;
        #1 v = stat_q;
        tick(1);
        rd_stb = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        tick(2);
        chk("R1 stat in reset", stat_q, 8'h00);
        chk("R1 irq in reset", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        irq_en = 1'b1;
        tick(8);
        chk("R9 no flag from lines high at reset", stat_q, 8'hF0);
        chk("R9 no irq after fill", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_cts_fall();
        logic [7:0] v;
        line_in = 4'b1110;
        tick(1);
        chk("R2 level not yet after one edge", stat_q, 8'hF0);
        tick(1);
        chk("R2 level after two edges", stat_q, 8'hE0);
        tick(1);
        chk("R3 R10 CTS flag only", stat_q, 8'hE1);
        host_read(v);
        chk("R6 read shows pre-clear value", v, 8'hE1);
        chk("R6 read clears flag", stat_q, 8'hE0);
    endtask

    task automatic t_ri_trail();
        logic [7:0] v;
        line_in = 4'b1010;
        tick(3);
        chk("R4 RI fall sets trailing flag", stat_q, 8'hA4);
        host_read(v);
        chk("R6 clear after RI read", stat_q, 8'hA0);
        line_in = 4'b1110;
        tick(4);
        chk("R4 RI rise sets nothing", stat_q, 8'hE0);
    endtask

    task automatic t_sticky();
        logic [7:0] v;
        line_in = 4'b1100;
        tick(4);
        line_in = 4'b1110;
        tick(8);
        chk("R5 DSR flag held over two changes", stat_q, 8'hE2);
        host_read(v);
        chk("R5 DSR read value", v, 8'hE2);
        chk("R6 DSR cleared", stat_q, 8'hE0);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        line_in = 4'b0110;
        tick(2);
        host_read(v);
        chk("R7 value during colliding read", v, 8'h60);
        chk("R7 flag kept after colliding read", stat_q, 8'h68);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        irq_en = 1'b0;
        #1;
        chk("R8 irq masked with flag pending", {7'b0, irq}, 8'h00);
        irq_en = 1'b1;
        #1;
        chk("R8 irq with flag and enable", {7'b0, irq}, 8'h01);
        host_read(v);
        chk("R8 irq drops after read", {7'b0, irq}, 8'h00);
        irq_en = 1'b0;
        line_in = 4'b1110;
        tick(3);
        chk("R3 DCD rise recorded with irq off", stat_q, 8'hE8);
        chk("R8 irq stays low when disabled", {7'b0, irq}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_cts_fall();
        t_ri_trail();
        t_sticky();
        t_collide();
        t_irq();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule